// File: doc/BRIEF.md
# Paged Open-Drain GPIO Register File

This block is the host-facing register file of a 48-line general-purpose I/O unit. A byte-wide host bus with a 4-bit address reaches six 8-bit port registers. Each port register drives eight open-drain pads. A bit set to 1 turns the pad's sink driver on and pulls the line low. A bit set to 0 releases the line so that it can act as an input. Reading a port returns the inverted pad level, so a high pin reads as 0.

A control register at offset 0x7 does two jobs. It selects which bank of three registers appears at offsets 0x8 to 0xA, and it can make individual ports read-only. The polarity bank, the enable bank and the interrupt-ID bank belong to a separate edge-detect interrupt unit. This block only forwards host accesses to them, with a bank code, an index and the data. Polarity and enable writes are forwarded. Interrupt-ID reads and writes are forwarded. The interrupt unit's three pending flags are readable at offset 0x6 on every page.

Top module: `gpio_paged_regfile`

## Requirements
- R1: After reset every port latch is zero, so every `pad_oe_o` bit is 0 and all lines are released. The page field is 0 and no port is locked.
- R2: A write to offset p (0x0 to 0x5) of an unlocked port loads `wdata_i` into latch p. From the next cycle this value appears on `pad_oe_o[8p+7:8p]`, whatever page is selected.
- R3: While `addr_i` is 0x0 to 0x5, `rdata_o` equals the bitwise inverse of the eight `pad_i` bits of that port, combinationally.
- R4: A write to offset 0x7 stores bits 7:6 as the page and bits 5:0 as lock flags, with bit p locking port p. A write to a locked port leaves its latch unchanged. Reads of a locked port still return the inverted pad level.
- R5: Reading offset 0x6 returns `{5'b0, edge_pend_i}`. A write to offset 0x6 changes no state.
- R6: On page 1 (polarity) and page 2 (enable), a write to offset 0x8+i (i = 0..2) raises `edge_wr_o` in the same cycle. In that cycle `edge_sel_o` equals the page, `edge_idx_o` equals i and `edge_wdata_o` equals `wdata_i`. Reads of these offsets on pages 1 and 2 return 0x00 and raise no strobe.
- R7: On page 3 (interrupt ID), a read of offset 0x8+i raises `edge_rd_o` with `edge_sel_o` = 3 and `edge_idx_o` = i, and returns `edge_rdata_i` on `rdata_o`. A write there is forwarded as in R6 with `edge_sel_o` = 3.
- R8: On page 0, offsets 0x8 to 0xA are unused: accesses there raise no strobe and read 0x00. Offset 0x7 reads 0x00. Offsets 0xB to 0xF read 0x00 and ignore writes.
- R9: Rewriting offset 0x7 with a lock bit cleared makes that port writable again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Host register offset |
| wdata_i | input | 8 | Host write data |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |
| pad_oe_o | output | 48 | Open-drain sink enables, 1 = pull low |
| pad_i | input | 48 | Pad levels |
| edge_wr_o | output | 1 | Forwarded write strobe to the interrupt unit |
| edge_rd_o | output | 1 | Forwarded read strobe to the interrupt unit |
| edge_sel_o | output | 2 | Bank code: 1 polarity, 2 enable, 3 interrupt ID |
| edge_idx_o | output | 2 | Register index within the bank (0..2) |
| edge_wdata_o | output | 8 | Forwarded write data |
| edge_rdata_i | input | 8 | Interrupt-ID read data from the interrupt unit |
| edge_pend_i | input | 3 | Pending flags from the interrupt unit |

## Verification
The bench attacks the points where the page field, the lock flags and the data inversion interact.

- It writes a locked port and expects the latch to hold. A design that ignored the lock would show the new byte on the pads. It then reads the same port and expects the inverted pad level. A design that blocked reads along with writes would return 0x00.
- It clears the lock and writes again, to catch a lock that sticks.
- It drives non-zero interrupt-ID data on page 0 and on page 3, to catch paged offsets decoded without regard to the page. Such a design would leak that data or forward strobes on page 0.
- It checks bank code, index and data on each forwarded access, which exposes swapped or off-by-one index arithmetic.
- It writes the pending and out-of-range offsets, which would corrupt a port latch if the address decode were too wide.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 8;
  localparam int PAGE_W    = 2;
  localparam int PAGE_LSB  = 6;
  localparam int OFS_PEND  = 6;
  localparam int OFS_PGLK  = 7;
  localparam int OFS_PAGED = 8;

  typedef enum logic [PAGE_W-1:0] {
    PG_PLAIN = 2'd0,
    PG_POL   = 2'd1,
    PG_ENAB  = 2'd2,
    PG_ID    = 2'd3
  } page_e;
endpackage

// File: rtl/gpr_addr_dec.sv
module gpr_addr_dec
  import gpr_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int NUM_PAGED = 3,
  localparam int IDX_W = (NUM_PAGED > 1) ? $clog2(NUM_PAGED) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_PORTS-1:0] port_hit_o,
  output logic              pend_hit_o,
  output logic              pglk_hit_o,
  output logic              paged_hit_o,
  output logic [IDX_W-1:0]  paged_idx_o
);
  logic [ADDR_W-1:0] rel_addr;

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      port_hit_o[p] = (addr_i == ADDR_W'(p));
    end
  end

  assign pend_hit_o  = (addr_i == ADDR_W'(OFS_PEND));
  assign pglk_hit_o  = (addr_i == ADDR_W'(OFS_PGLK));
  assign paged_hit_o = (addr_i >= ADDR_W'(OFS_PAGED)) &&
                       (addr_i <  ADDR_W'(OFS_PAGED + NUM_PAGED));
  assign rel_addr    = addr_i - ADDR_W'(OFS_PAGED);
  assign paged_idx_o = rel_addr[IDX_W-1:0];
endmodule

// File: rtl/gpr_port_bank.sv
module gpr_port_bank
  import gpr_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  localparam int LINES = NUM_PORTS * DATA_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [NUM_PORTS-1:0] port_hit_i,
  input  logic [NUM_PORTS-1:0] lock_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [LINES-1:0]     latch_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [DATA_W-1:0] latch_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        latch_q <= '0;
      end else if (wr_i && port_hit_i[p] && !lock_i[p]) begin
        latch_q <= wdata_i;
      end
    end

    assign latch_o[p*DATA_W +: DATA_W] = latch_q;
  end
endmodule

// File: rtl/gpr_rd_mux.sv
module gpr_rd_mux
  import gpr_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int NUM_PAGED = 3,
  localparam int LINES = NUM_PORTS * DATA_W
) (
  input  logic [NUM_PORTS-1:0] port_hit_i,
  input  logic                 pend_hit_i,
  input  logic                 paged_hit_i,
  input  page_e                page_i,
  input  logic [LINES-1:0]     pad_i,
  input  logic [NUM_PAGED-1:0] pend_i,
  input  logic [DATA_W-1:0]    id_rdata_i,
  output logic [DATA_W-1:0]    rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      // pads read back inverted
      if (port_hit_i[p]) rdata_o = ~pad_i[p*DATA_W +: DATA_W];
    end
    if (pend_hit_i) rdata_o = {{(DATA_W-NUM_PAGED){1'b0}}, pend_i};
    if (paged_hit_i && page_i == PG_ID) rdata_o = id_rdata_i;
  end
endmodule

// File: rtl/gpio_paged_regfile.sv
module gpio_paged_regfile
  import gpr_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int NUM_PAGED = 3,
  localparam int LINES = NUM_PORTS * DATA_W,
  localparam int IDX_W = (NUM_PAGED > 1) ? $clog2(NUM_PAGED) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [LINES-1:0]     pad_oe_o,
  input  logic [LINES-1:0]     pad_i,
  output logic                 edge_wr_o,
  output logic                 edge_rd_o,
  output logic [PAGE_W-1:0]    edge_sel_o,
  output logic [IDX_W-1:0]     edge_idx_o,
  output logic [DATA_W-1:0]    edge_wdata_o,
  input  logic [DATA_W-1:0]    edge_rdata_i,
  input  logic [NUM_PAGED-1:0] edge_pend_i
);
  logic [NUM_PORTS-1:0] port_hit;
  logic                 pend_hit, pglk_hit, paged_hit;
  logic [IDX_W-1:0]     paged_idx;
  page_e                page_q;
  logic [NUM_PORTS-1:0] lock_q;

  gpr_addr_dec #(.NUM_PORTS(NUM_PORTS), .NUM_PAGED(NUM_PAGED)) dec_i (
    .addr_i      (addr_i),
    .port_hit_o  (port_hit),
    .pend_hit_o  (pend_hit),
    .pglk_hit_o  (pglk_hit),
    .paged_hit_o (paged_hit),
    .paged_idx_o (paged_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= PG_PLAIN;
      lock_q <= '0;
    end else if (wr_i && pglk_hit) begin
      page_q <= page_e'(wdata_i[PAGE_LSB +: PAGE_W]);
      lock_q <= wdata_i[NUM_PORTS-1:0];
    end
  end

  gpr_port_bank #(.NUM_PORTS(NUM_PORTS)) bank_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .port_hit_i (port_hit),
    .lock_i     (lock_q),
    .wdata_i    (wdata_i),
    .latch_o    (pad_oe_o)
  );

  gpr_rd_mux #(.NUM_PORTS(NUM_PORTS), .NUM_PAGED(NUM_PAGED)) mux_i (
    .port_hit_i  (port_hit),
    .pend_hit_i  (pend_hit),
    .paged_hit_i (paged_hit),
    .page_i      (page_q),
    .pad_i       (pad_i),
    .pend_i      (edge_pend_i),
    .id_rdata_i  (edge_rdata_i),
    .rdata_o     (rdata_o)
  );

  // page 0 leaves the paged window unused; only the ID bank is readable
  assign edge_wr_o    = wr_i && paged_hit && (page_q != PG_PLAIN);
  assign edge_rd_o    = rd_i && paged_hit && (page_q == PG_ID);
  assign edge_sel_o   = page_q;
  assign edge_idx_o   = paged_idx;
  assign edge_wdata_o = wdata_i;
endmodule

// File: rtl/gpr_checker.sv
module gpr_checker
  import gpr_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int NUM_PAGED = 3,
  localparam int LINES = NUM_PORTS * DATA_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [DATA_W-1:0]    wdata_i,
  input logic                 wr_i,
  input logic [DATA_W-1:0]    rdata_o,
  input logic [LINES-1:0]     pad_oe_o,
  input logic [LINES-1:0]     pad_i,
  input logic                 edge_wr_o,
  input logic                 edge_rd_o,
  input logic [NUM_PAGED-1:0] edge_pend_i,
  input logic [PAGE_W-1:0]    page_q,
  input logic [NUM_PORTS-1:0] lock_q
);
  logic paged_acc;
  assign paged_acc = (addr_i >= ADDR_W'(OFS_PAGED)) &&
                     (addr_i <  ADDR_W'(OFS_PAGED + NUM_PAGED));

  AST_RESET_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pad_oe_o == '0)); // R1

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    AST_PORT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == ADDR_W'(p) && !lock_q[p]) |=>
      (pad_oe_o[p*DATA_W +: DATA_W] == $past(wdata_i))); // R2
    AST_PORT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i == ADDR_W'(p)) |-> (rdata_o == ~pad_i[p*DATA_W +: DATA_W])); // R3
    AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == ADDR_W'(p) && lock_q[p]) |=>
      $stable(pad_oe_o[p*DATA_W +: DATA_W])); // R4
  end

  AST_PEND_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFS_PEND)) |->
    (rdata_o == {{(DATA_W-NUM_PAGED){1'b0}}, edge_pend_i})); // R5
  AST_FWD_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && paged_acc && page_q != 2'd0) |-> edge_wr_o); // R6
  AST_ID_READ_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_rd_o |-> (page_q == 2'd3)); // R7
  AST_PAGE0_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_q == 2'd0) |-> (!edge_wr_o && !edge_rd_o)); // R8
endmodule

bind gpio_paged_regfile gpr_checker #(.NUM_PORTS(NUM_PORTS), .NUM_PAGED(NUM_PAGED)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .wr_i        (wr_i),
  .rdata_o     (rdata_o),
  .pad_oe_o    (pad_oe_o),
  .pad_i       (pad_i),
  .edge_wr_o   (edge_wr_o),
  .edge_rd_o   (edge_rd_o),
  .edge_pend_i (edge_pend_i),
  .page_q      (page_q),
  .lock_q      (lock_q)
);

// File: tb/gpio_paged_regfile_tb_top.sv
module gpio_paged_regfile_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [7:0]  rdata_o;
  logic [47:0] pad_oe_o;
  logic [47:0] pad_i = '0;
  logic        edge_wr_o, edge_rd_o;
  logic [1:0]  edge_sel_o, edge_idx_o;
  logic [7:0]  edge_wdata_o;
  logic [7:0]  edge_rdata_i = '0;
  logic [2:0]  edge_pend_i = '0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  // kind: 0 rdata, 1 pad_oe byte, 2 forward bundle, 3 strobes only
  typedef struct {
    int          due;
    int          kind;
    int          idx;
    logic [15:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];

  always #2 clk_i = ~clk_i;

  gpio_paged_regfile dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .pad_oe_o(pad_oe_o),
    .pad_i(pad_i), .edge_wr_o(edge_wr_o), .edge_rd_o(edge_rd_o),
    .edge_sel_o(edge_sel_o), .edge_idx_o(edge_idx_o),
    .edge_wdata_o(edge_wdata_o), .edge_rdata_i(edge_rdata_i),
    .edge_pend_i(edge_pend_i)
  );

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [15:0] observe(int kind, int idx);
    case (kind)
      0:       return {8'h00, rdata_o};
      1:       return {8'h00, pad_oe_o[idx*8 +: 8]};
      2:       return {2'b00, edge_wr_o, edge_rd_o, edge_sel_o, edge_idx_o, edge_wdata_o};
      default: return {14'h0, edge_wr_o, edge_rd_o};
    endcase
  endfunction

  // monitor
  always @(negedge clk_i) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      item_t it;
      logic [15:0] got;
      it  = sb_q.pop_front();
      got = observe(it.kind, it.idx);
      checks++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                 it.req, it.kind, it.idx, got, it.exp);
      end
    end
  end

  task automatic expect_item(int kind, int idx, logic [15:0] exp, string req);
    item_t it;
    it.due = cyc; it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic op_start(bit wr, bit rd, logic [3:0] a, logic [7:0] d);
    @(posedge clk_i); #1;
    addr_i = a; wdata_i = d; wr_i = wr; rd_i = rd;
  endtask

  task automatic op_end();
    @(posedge clk_i); #1;
    wr_i = 1'b0; rd_i = 1'b0;
  endtask

  task automatic host_wr(logic [3:0] a, logic [7:0] d);
    op_start(1'b1, 1'b0, a, d);
    op_end();
  endtask

  task automatic read_chk(logic [3:0] a, logic [7:0] exp, string req);
    op_start(1'b0, 1'b1, a, 8'h00);
    expect_item(0, 0, {8'h00, exp}, req);
    op_end();
  endtask

  function automatic logic [15:0] bundle(bit w, bit r, logic [1:0] s, logic [1:0] i, logic [7:0] d);
    return {2'b00, w, r, s, i, d};
  endfunction

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    pad_i = 48'h0123_4567_89AB;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    // R1 reset state
    for (int p = 0; p < 6; p++) expect_item(1, p, 16'h0000, "R1");
    op_start(1'b0, 1'b1, 4'h9, 8'h00);
    expect_item(0, 0, 16'h0000, "R1");
    expect_item(3, 0, 16'h0000, "R1");
    op_end();

    // R2 port writes
    host_wr(4'h0, 8'hA5); expect_item(1, 0, 16'h00A5, "R2");
    host_wr(4'h5, 8'h3C); expect_item(1, 5, 16'h003C, "R2");

    // R3 inverted read-back
    read_chk(4'h2, 8'h98, "R3");
    read_chk(4'h5, 8'hFE, "R3");
    read_chk(4'h0, 8'h54, "R3");

    // R5 pending register
    edge_pend_i = 3'b101;
    read_chk(4'h6, 8'h05, "R5");
    host_wr(4'h6, 8'hFF);
    expect_item(1, 0, 16'h00A5, "R5");
    expect_item(1, 5, 16'h003C, "R5");

    // R4 page 1 with port 0 locked
    host_wr(4'h7, 8'h41);
    host_wr(4'h0, 8'hFF); expect_item(1, 0, 16'h00A5, "R4");
    read_chk(4'h0, 8'h54, "R4");
    host_wr(4'h1, 8'h11); expect_item(1, 1, 16'h0011, "R4");

    // R6 polarity bank forwarding
    op_start(1'b1, 1'b0, 4'h9, 8'h77);
    expect_item(2, 0, bundle(1'b1, 1'b0, 2'd1, 2'd1, 8'h77), "R6");
    op_end();
    edge_rdata_i = 8'h5A;
    op_start(1'b0, 1'b1, 4'h8, 8'h00);
    expect_item(0, 0, 16'h0000, "R6");
    expect_item(3, 0, 16'h0000, "R6");
    op_end();

    // R9 unlock, page 2
    host_wr(4'h7, 8'h80);
    host_wr(4'h0, 8'h0F); expect_item(1, 0, 16'h000F, "R9");
    op_start(1'b1, 1'b0, 4'hA, 8'h33);
    expect_item(2, 0, bundle(1'b1, 1'b0, 2'd2, 2'd2, 8'h33), "R6");
    op_end();
    read_chk(4'h9, 8'h00, "R6");

    // R7 interrupt-ID bank
    host_wr(4'h7, 8'hC0);
    op_start(1'b0, 1'b1, 4'h8, 8'h00);
    expect_item(0, 0, 16'h005A, "R7");
    expect_item(2, 0, bundle(1'b0, 1'b1, 2'd3, 2'd0, 8'h00), "R7");
    op_end();
    op_start(1'b1, 1'b0, 4'hA, 8'hC3);
    expect_item(2, 0, bundle(1'b1, 1'b0, 2'd3, 2'd2, 8'hC3), "R7");
    op_end();
    host_wr(4'h3, 8'hE7); expect_item(1, 3, 16'h00E7, "R2");

    // R8 page 0 and unused offsets
    host_wr(4'h7, 8'h00);
    op_start(1'b1, 1'b0, 4'h8, 8'h99);
    expect_item(3, 0, 16'h0000, "R8");
    op_end();
    op_start(1'b0, 1'b1, 4'h8, 8'h00);
    expect_item(0, 0, 16'h0000, "R8");
    expect_item(3, 0, 16'h0000, "R8");
    op_end();
    read_chk(4'h7, 8'h00, "R8");
    host_wr(4'hB, 8'hFF);
    expect_item(1, 0, 16'h000F, "R8");
    expect_item(1, 1, 16'h0011, "R8");
    expect_item(1, 3, 16'h00E7, "R8");
    expect_item(1, 5, 16'h003C, "R8");
    read_chk(4'hF, 8'h00, "R8");

    repeat (3) @(posedge clk_i);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule